// File: doc/BRIEF.md
# CompactFlash Slot Power Sequencer

This block manages power and card reset for a hot-swappable CompactFlash socket. It watches an active-low card-detect line. The line is synchronized and debounced. A filtered falling level means a card was inserted, and a filtered rising level means the card was removed. On insertion the block turns on the slot supply switch and waits a settling interval with card reset released. It then drives a low reset pulse of fixed minimum width and releases the card for use.

A software reset bit can hold the card in reset at any time, independently of the sequence. The board reset forces everything off. The card's ready/busy line is synchronized and presented as an interrupt-ready flag. The flag is valid only once the card is powered, its reset pulse is over and no software reset is applied. Both intervals are given as times and converted to clock cycles by rounding up, from a clock-frequency parameter.

Top module: `cf_slot_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `slot_pwr_en`=0, `card_rst_n`=0 and `card_irq_ready`=0. At the first edge with `rst_n` high and `soft_rst`=0, `card_rst_n` goes to 1.
- R2: The detect line is filtered. A level on `cf_cd_n` held for fewer than DEB_CYCLES consecutive cycles (after a two-flop synchronizer) causes no change at any output.
- R3: When `cf_cd_n` falls and stays low, `slot_pwr_en` (active level 1) rises exactly DEB_CYCLES+3 clock edges after the first edge that samples the low level.
- R4: After `slot_pwr_en` rises, `card_rst_n` stays high for exactly SETTLE_CYC = ceil(CLK_KHZ*SETTLE_US/1000) cycles and then falls.
- R5: The low reset pulse lasts exactly PULSE_CYC = ceil(CLK_KHZ*PULSE_NS/1000000) cycles. A software reset released during the pulse does not shorten it.
- R6: `card_irq_ready` is 1 only after the pulse has ended, while power is on, `soft_rst` was 0 at the previous edge and the synchronized `card_rdy` (1 = ready, 0 = busy) is 1. A change on `card_rdy` reaches it 2 edges later.
- R7: When `cf_cd_n` rises and stays high, `slot_pwr_en` and `card_irq_ready` drop DEB_CYCLES+3 edges later, from the settle, pulse or live phase. A reset pulse in progress is abandoned: `card_rst_n` returns high at that same edge unless `soft_rst` is set.
- R8: `soft_rst`=1 drives `card_rst_n` and `card_irq_ready` low one edge later in any phase, including with no card. `soft_rst`=0 lets them return one edge later, unless the sequencer's own pulse still holds reset. The bit does not change the sequence timing.
- R9: A board reset while a card is live drops power at the next edge. A card still present when `rst_n` rises is then treated as a new insertion with the full timing of R3 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single block clock |
| rst_n | input | 1 | Board reset, synchronous, active low |
| cf_cd_n | input | 1 | Card detect from socket, low when a card is seated |
| soft_rst | input | 1 | Software card-reset bit, 1 forces card reset |
| card_rdy | input | 1 | Card ready/busy line, 1 = ready |
| slot_pwr_en | output | 1 | Slot supply switch enable, active high |
| card_rst_n | output | 1 | Card reset, active low |
| card_irq_ready | output | 1 | Card powered, out of reset and reporting ready |

## Verification
Every sequencer state shows up at the ports as a distinct mix of supply enable, reset level and ready flag. A wrong state or a wrong timer value therefore shows up as an output edge at the wrong cycle. The bench predicts every output edge to the exact cycle and treats any output edge it did not predict as an error. A miscounted settle or pulse interval is caught on the very cycle the reset edge lands. A stuck or missed detect transition is caught DEB_CYCLES+3 cycles after the socket change. A debounce that lets glitches through shows as a power edge during the glitch test.

// File: rtl/cf_seq_pkg.sv
// Shared types and helpers for the slot power sequencer.
// Assumes: the cycle conversion is evaluated at elaboration only.
package cf_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SETTLE = 2'd1,
        SEQ_PULSE  = 2'd2,
        SEQ_LIVE   = 2'd3
    } seq_state_t;

    // Integer division rounded toward plus infinity (whole cycles).
    function automatic int cyc_ceil(input longint num, input longint den);
        return int'((num + den - 1) / den);
    endfunction

endpackage

// File: rtl/cf_sync2.sv
// Two-flop synchronizer for slow asynchronous levels.
// Assumes: inputs change far slower than clk; reset value is a parameter so
// each line can come out of reset at its own idle level.
module cf_sync2 #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    // Shift the level through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/cf_detect_filter.sv
// Debounce of the synchronized card-detect level plus edge extraction.
// The filtered level follows the input only after it has differed for
// DEB_CYCLES consecutive cycles; any return to the old level restarts the
// count. Produces one-cycle insert (falling) and remove (rising) pulses.
// Assumes: DEB_CYCLES >= 1; reset treats the slot as empty.
module cf_detect_filter #(
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cd_sync_n,
    output logic ins_pulse,
    output logic rem_pulse
);

    localparam int DW = $clog2(DEB_CYCLES + 1);

    logic          level_n;
    logic          level_d_n;
    logic [DW-1:0] run_cnt;

    // Count consecutive mismatches and adopt the new level when the run is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_n   <= 1'b1;
            level_d_n <= 1'b1;
            run_cnt   <= '0;
        end else begin
            level_d_n <= level_n;
            if (cd_sync_n == level_n) begin
                run_cnt <= '0;
            end else if (run_cnt == DW'(DEB_CYCLES - 1)) begin
                level_n <= cd_sync_n;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // Edges of the filtered level.
    assign ins_pulse = level_d_n & ~level_n;
    assign rem_pulse = ~level_d_n & level_n;

    AST_DEB_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt < DW'(DEB_CYCLES)); // R2
    AST_DEB_FLIP_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (level_n != $past(level_n)) |-> ($past(run_cnt) == DW'(DEB_CYCLES - 1))); // R2

endmodule

// File: rtl/cf_power_fsm.sv
// Slot sequencing state machine with a shared interval timer.
// IDLE -> SETTLE on insert (supply on, reset released), SETTLE -> PULSE after
// SETTLE_CYC cycles, PULSE -> LIVE after PULSE_CYC cycles. Removal returns
// to IDLE from any powered phase. Outputs are registered from the next state
// so they change on the same edge as the state.
// Assumes: SETTLE_CYC >= 1 and PULSE_CYC >= 1.
module cf_power_fsm
    import cf_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 100000,
    parameter int PULSE_CYC  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ins_pulse,
    input  logic rem_pulse,
    output logic pwr_q,
    output logic pulse_q,
    output logic live_q
);

    localparam int MAX_CYC = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
    localparam int TW      = $clog2(MAX_CYC + 1);

    seq_state_t    state, nxt;
    logic [TW-1:0] tmr, tmr_nxt;

    // Next-state and timer decision.
    always_comb begin
        nxt     = state;
        tmr_nxt = tmr;
        unique case (state)
            SEQ_IDLE: begin
                if (ins_pulse) begin
                    nxt     = SEQ_SETTLE;
                    tmr_nxt = '0;
                end
            end
            SEQ_SETTLE: begin
                if (tmr == TW'(SETTLE_CYC - 1)) begin
                    nxt     = SEQ_PULSE;
                    tmr_nxt = '0;
                end else begin
                    tmr_nxt = tmr + 1'b1;
                end
            end
            SEQ_PULSE: begin
                if (tmr == TW'(PULSE_CYC - 1)) begin
                    nxt     = SEQ_LIVE;
                    tmr_nxt = '0;
                end else begin
                    tmr_nxt = tmr + 1'b1;
                end
            end
            default: begin
                nxt = SEQ_LIVE;
            end
        endcase
        if (rem_pulse && (state != SEQ_IDLE)) begin
            nxt     = SEQ_IDLE;
            tmr_nxt = '0;
        end
    end

    // State, timer and registered phase outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            tmr     <= '0;
            pwr_q   <= 1'b0;
            pulse_q <= 1'b0;
            live_q  <= 1'b0;
        end else begin
            state   <= nxt;
            tmr     <= tmr_nxt;
            pwr_q   <= (nxt != SEQ_IDLE);
            pulse_q <= (nxt == SEQ_PULSE);
            live_q  <= (nxt == SEQ_LIVE);
        end
    end

    AST_PWR_FROM_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_q) |-> $past(ins_pulse)); // R3
    AST_PULSE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q && !$past(pulse_q)) |-> ($past(state) == SEQ_SETTLE)); // R4
    AST_PULSE_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (tmr < TW'(PULSE_CYC))); // R5
    AST_LIVE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(live_q) |-> $past(pulse_q)); // R5
    AST_REMOVE_DROPS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_pulse && (state != SEQ_IDLE)) |=> !pwr_q); // R7

endmodule

// File: rtl/cf_slot_sequencer.sv
// Top of the CompactFlash slot power sequencer.
// Synchronizes card detect and ready/busy, debounces detect, runs the
// power/reset sequence and merges the software reset bit into the card
// reset and the ready flag. Intervals are given in time units and turned
// into whole cycles (rounded up) from CLK_KHZ.
// Assumes: soft_rst comes from logic on clk; cf_cd_n and card_rdy are
// asynchronous; rst_n is synchronous to clk.
module cf_slot_sequencer
    import cf_seq_pkg::*;
#(
    parameter int CLK_KHZ    = 100000,
    parameter int SETTLE_US  = 1000,
    parameter int PULSE_NS   = 10000,
    parameter int DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cf_cd_n,
    input  logic soft_rst,
    input  logic card_rdy,
    output logic slot_pwr_en,
    output logic card_rst_n,
    output logic card_irq_ready
);

    localparam int SETTLE_CYC = cyc_ceil(longint'(CLK_KHZ) * longint'(SETTLE_US), 64'd1000);
    localparam int PULSE_CYC  = cyc_ceil(longint'(CLK_KHZ) * longint'(PULSE_NS), 64'd1000000);

    logic cd_s_n;
    logic rdy_s;
    logic ins_pulse;
    logic rem_pulse;
    logic pulse_q;
    logic live_q;
    logic sw_clear_q;

    cf_sync2 #(.W(1), .RST_VAL(1'b1)) u_cd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cf_cd_n),
        .q     (cd_s_n)
    );

    cf_sync2 #(.W(1), .RST_VAL(1'b0)) u_rdy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (card_rdy),
        .q     (rdy_s)
    );

    cf_detect_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cd_sync_n (cd_s_n),
        .ins_pulse (ins_pulse),
        .rem_pulse (rem_pulse)
    );

    cf_power_fsm #(.SETTLE_CYC(SETTLE_CYC), .PULSE_CYC(PULSE_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_pulse (ins_pulse),
        .rem_pulse (rem_pulse),
        .pwr_q     (slot_pwr_en),
        .pulse_q   (pulse_q),
        .live_q    (live_q)
    );

    // Register the software reset request; board reset holds the card in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_clear_q <= 1'b0;
        end else begin
            sw_clear_q <= ~soft_rst;
        end
    end

    // Merge the sequencer pulse with the software and board reset.
    assign card_rst_n     = sw_clear_q & ~pulse_q;
    // Ready flag only when live, not held by software, and card reports ready.
    assign card_irq_ready = live_q & sw_clear_q & rdy_s;

    AST_SOFT_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !card_rst_n); // R8
    AST_READY_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        card_irq_ready |-> slot_pwr_en); // R6
    AST_READY_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        card_irq_ready |-> card_rst_n); // R6

endmodule

// File: tb/sim_cf_slot_sequencer.sv
`timescale 1ns/1ps
module sim_cf_slot_sequencer;

    localparam int CLK_KHZ = 250000;
    localparam int SET_US  = 4;
    localparam int PUL_NS  = 402;
    localparam int DEB     = 8;
    // Expected intervals from the requirement formulas (rounded up).
    localparam int S_CYC   = (CLK_KHZ * SET_US + 999) / 1000;      // 1000
    localparam int P_CYC   = (CLK_KHZ * PUL_NS + 999999) / 1000000; // 101
    localparam int LAT     = DEB + 3;

    logic clk = 1'b0;
    logic rst_n, cf_cd_n, soft_rst, card_rdy;
    logic slot_pwr_en, card_rst_n, card_irq_ready;

    always #2 clk = ~clk;

    cf_slot_sequencer #(
        .CLK_KHZ(CLK_KHZ), .SETTLE_US(SET_US), .PULSE_NS(PUL_NS), .DEB_CYCLES(DEB)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cf_cd_n(cf_cd_n), .soft_rst(soft_rst),
        .card_rdy(card_rdy), .slot_pwr_en(slot_pwr_en), .card_rst_n(card_rst_n),
        .card_irq_ready(card_irq_ready)
    );

    typedef struct {
        int    sig;
        logic  val;
        int    at;
        string req;
    } ev_t;

    ev_t   evq[$];
    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    logic  mon_en = 1'b0;
    logic  prev [3];
    string cur_req = "R1";
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic sig_val(int s);
        case (s)
            0:       return slot_pwr_en;
            1:       return card_rst_n;
            default: return card_irq_ready;
        endcase
    endfunction

    task automatic push(int s, logic v, int at, string req);
        evq.push_back('{s, v, at, req});
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic act, logic exp, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic drain(string req);
        n_cmp++;
        if (evq.size() != 0) begin
            n_bad++;
            $display("FAIL %s: %0d predicted edges missing, actual 0 expected %0d remaining, next sig %0d at %0d",
                     req, evq.size(), 0, evq[0].sig, evq[0].at);
            evq.delete();
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: every output edge must match the head of the expected queue.
    always @(negedge clk) begin
        if (mon_en) begin
            for (int s = 0; s < 3; s++) begin
                logic v;
                v = sig_val(s);
                if (v !== prev[s]) begin
                    n_cmp++;
                    if (evq.size() == 0) begin
                        n_bad++;
                        $display("FAIL %s: unexpected edge sig %0d to %b at %0d, expected no edge",
                                 cur_req, s, v, cyc);
                    end else begin
                        ev_t e;
                        e = evq.pop_front();
                        if (e.sig != s || e.val !== v || e.at != cyc) begin
                            n_bad++;
                            $display("FAIL %s: actual sig %0d=%b at %0d, expected sig %0d=%b at %0d",
                                     e.req, s, v, cyc, e.sig, e.val, e.at);
                        end
                    end
                    prev[s] = v;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    // Full insertion from the current cycle with ready already high.
    task automatic insert_full(string req);
        int c;
        c = cyc;
        cf_cd_n = 1'b0;
        push(0, 1'b1, c + LAT, "R3");
        push(1, 1'b0, c + LAT + S_CYC, "R4");
        push(1, 1'b1, c + LAT + S_CYC + P_CYC, "R5");
        push(2, 1'b1, c + LAT + S_CYC + P_CYC, "R6");
        step(LAT + S_CYC + P_CYC + 6);
        drain(req);
    endtask

    initial begin
        int c, c0;
        rst_n = 1'b0; cf_cd_n = 1'b1; soft_rst = 1'b0; card_rdy = 1'b1;
        step(5);
        // R1 reset state
        chk("R1", slot_pwr_en, 1'b0, "power in reset");
        chk("R1", card_rst_n, 1'b0, "card reset in reset");
        chk("R1", card_irq_ready, 1'b0, "ready in reset");
        for (int s = 0; s < 3; s++) prev[s] = sig_val(s);
        mon_en = 1'b1;
        c = cyc; rst_n = 1'b1;
        push(1, 1'b1, c + 1, "R1");
        step(4); drain("R1");

        // R2 short glitch on detect is ignored
        cur_req = "R2";
        cf_cd_n = 1'b0; step(DEB - 2); cf_cd_n = 1'b1;
        step(40); drain("R2");

        // R3..R6 full insertion
        cur_req = "R4";
        insert_full("R5");

        // R6 ready/busy follows with 2-edge latency
        cur_req = "R6";
        c = cyc; card_rdy = 1'b0; push(2, 1'b0, c + 2, "R6");
        step(10);
        c = cyc; card_rdy = 1'b1; push(2, 1'b1, c + 2, "R6");
        step(10); drain("R6");

        // R8 software reset while live
        cur_req = "R8";
        c = cyc; soft_rst = 1'b1;
        push(1, 1'b0, c + 1, "R8"); push(2, 1'b0, c + 1, "R8");
        step(5);
        c = cyc; soft_rst = 1'b0;
        push(1, 1'b1, c + 1, "R8"); push(2, 1'b1, c + 1, "R8");
        step(5); drain("R8");

        // R7 removal while live
        cur_req = "R7";
        c = cyc; cf_cd_n = 1'b1;
        push(0, 1'b0, c + LAT, "R7"); push(2, 1'b0, c + LAT, "R7");
        step(LAT + 10); drain("R7");

        // R8 software reset with no card
        cur_req = "R8";
        c = cyc; soft_rst = 1'b1; push(1, 1'b0, c + 1, "R8");
        step(5);
        c = cyc; soft_rst = 1'b0; push(1, 1'b1, c + 1, "R8");
        step(5); drain("R8");

        // R7 removal in the middle of the reset pulse
        cur_req = "R7";
        c0 = cyc; cf_cd_n = 1'b0;
        push(0, 1'b1, c0 + LAT, "R3");
        push(1, 1'b0, c0 + LAT + S_CYC, "R4");
        step(S_CYC + 20);
        c = cyc; cf_cd_n = 1'b1;
        push(0, 1'b0, c + LAT, "R7"); push(1, 1'b1, c + LAT, "R7");
        step(LAT + 30); drain("R7");

        // R7 removal during settle: no reset activity at all
        c0 = cyc; cf_cd_n = 1'b0;
        push(0, 1'b1, c0 + LAT, "R3");
        step(100);
        c = cyc; cf_cd_n = 1'b1;
        push(0, 1'b0, c + LAT, "R7");
        step(LAT + S_CYC + P_CYC + 30); drain("R7");

        // R8/R5 software reset during settle, released inside the pulse
        cur_req = "R5";
        c0 = cyc; cf_cd_n = 1'b0;
        push(0, 1'b1, c0 + LAT, "R3");
        step(LAT + 50);
        c = cyc; soft_rst = 1'b1; push(1, 1'b0, c + 1, "R8");
        step(S_CYC);
        soft_rst = 1'b0;
        push(1, 1'b1, c0 + LAT + S_CYC + P_CYC, "R5");
        push(2, 1'b1, c0 + LAT + S_CYC + P_CYC, "R6");
        step(P_CYC); drain("R5");

        // R9 board reset while live, card stays seated
        cur_req = "R9";
        c = cyc; rst_n = 1'b0;
        push(0, 1'b0, c + 1, "R9"); push(1, 1'b0, c + 1, "R9"); push(2, 1'b0, c + 1, "R9");
        step(5);
        c = cyc; rst_n = 1'b1;
        push(1, 1'b1, c + 1, "R1");
        push(0, 1'b1, c + LAT, "R9");
        push(1, 1'b0, c + LAT + S_CYC, "R9");
        push(1, 1'b1, c + LAT + S_CYC + P_CYC, "R9");
        push(2, 1'b1, c + LAT + S_CYC + P_CYC, "R9");
        step(LAT + S_CYC + P_CYC + 6); drain("R9");

        // Final removal
        cur_req = "R7";
        c = cyc; cf_cd_n = 1'b1;
        push(0, 1'b0, c + LAT, "R7"); push(2, 1'b0, c + LAT, "R7");
        step(LAT + 10); drain("R7");

        chk("R7", slot_pwr_en, 1'b0, "power after final removal");
        done = 1'b1;
        summary();
    end

endmodule